// File: doc/BRIEF.md
# Two-Wire Dual Wiper Register Slave

This block is a slave on a two-wire serial bus (clock plus open-drain data) that owns two 8-bit wiper position registers. A fast system clock oversamples the bus lines through synchronizers and a digital pulse filter. The filtered lines yield START, repeated START, STOP and clock-edge events. A byte engine shifts bits in and out most significant bit first, recognises its own control byte, and drives the acknowledge bit.

A write transfer carries a command byte and then data bytes. One command loads wiper 0 and may roll over into wiper 1. One loads wiper 1 only. One loads a single value into both wipers. A read transfer streams wiper 0, then wiper 1, and keeps alternating for as long as the master acknowledges. The two register values are driven straight out to the analog side. The data line is driven only through a pull-low enable.

Top module: `dual_wiper_i2c_ctrl`

## Requirements
- R1: After reset both wiper outputs are 00h and the data line is not pulled low.
- R2: A control byte whose upper four bits are 0101, whose next three bits equal the strap inputs, and whose least significant bit is the direction (1 read, 0 write) is acknowledged by holding data low through the high phase of the ninth clock.
- R3: A control byte with a different code or strap value is not acknowledged. The block then leaves the bus alone and changes no wiper until the next START.
- R4: With command A9h, the first data byte loads wiper 0 and a second data byte loads wiper 1. Further data bytes are acknowledged and discarded.
- R5: With command AAh, the first data byte loads wiper 1 only. Wiper 0 keeps its value.
- R6: With command AFh, one data byte loads both wipers with the same value. Later bytes are acknowledged and discarded.
- R7: Any other command byte is not acknowledged, and the data bytes that follow it write nothing.
- R8: A read returns wiper 0 first, then wiper 1, and alternates between them for each byte the master acknowledges.
- R9: After the master does not acknowledge a read byte, the block releases the data line.
- R10: A repeated START without a STOP begins a new transfer that is decoded from its control byte.
- R11: A pulse on either bus line shorter than FILT_CYCLES system clocks has no effect on the protocol.
- R12: The pull-low enable is asserted only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_strap | input | 3 | Device select straps compared with control byte bits 3..1 |
| wiper0 | output | 8 | Wiper 0 position register |
| wiper1 | output | 8 | Wiper 1 position register |
| sda_pull_low | output | 1 | When high, the external open-drain driver pulls data low |

## Verification
The assertions guard properties that hold on every cycle:
- the reset value of both wipers;
- a rising pull-low enable only during a low filtered clock;
- no data drive while the slave is idle;
- wiper updates only on a sampled clock rise;
- release of the data line after a master not-acknowledge;
- filter output changes only after a settled input.

The bench scenarios show what a single cycle cannot:
- the acknowledge or not-acknowledge of each control byte and command;
- which wiper each write command loads, and that surplus bytes are discarded;
- the pot-0/pot-1 alternation on long reads;
- decoding after a repeated START;
- rejection of a short clock glitch in the middle of a transfer.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_LOAD_W0   = 8'hA9;
    localparam logic [BYTE_W-1:0] CMD_LOAD_W1   = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_LOAD_BOTH = 8'hAF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK,
        ST_TX,
        ST_MACK
    } slv_state_e;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_CMD,
        PH_DATA
    } rx_phase_e;

    typedef enum logic [1:0] {
        WM_W0_ROLL,
        WM_W1_ONLY,
        WM_BOTH
    } wr_mode_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_evt_t;

    function automatic logic ctrl_hit(input logic [BYTE_W-1:0] b,
                                      input logic [3:0] code,
                                      input logic [2:0] strap);
        return (b[7:4] == code) && (b[3:1] == strap);
    endfunction

    function automatic logic cmd_known(input logic [BYTE_W-1:0] b);
        return (b == CMD_LOAD_W0) || (b == CMD_LOAD_W1) || (b == CMD_LOAD_BOTH);
    endfunction

    function automatic wr_mode_e cmd_mode(input logic [BYTE_W-1:0] b);
        if (b == CMD_LOAD_W1)
            return WM_W1_ONLY;
        else if (b == CMD_LOAD_BOTH)
            return WM_BOTH;
        return WM_W0_ROLL;
    endfunction

endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_q;
    logic                   settled;

    assign settled = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            run_q   <= '0;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            if (settled == clean_o) begin
                run_q <= '0;
            end else if (run_q == CNT_W'(FILT_CYCLES - 1)) begin
                clean_o <= settled;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R11
    filt_settled_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(clean_o) |-> ($past(settled, 1) == $past(settled, 2)));

endmodule

// File: rtl/bus_event_detect.sv
module bus_event_detect
    import wiper_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_c,
    input  logic     sda_c,
    output bus_evt_t evt_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_c;
            sda_q <= sda_c;
        end
    end

    always_comb begin
        evt_o.start = scl_c && scl_q && sda_q && !sda_c;
        evt_o.stop  = scl_c && scl_q && !sda_q && sda_c;
        evt_o.rise  = scl_c && !scl_q;
        evt_o.fall  = !scl_c && scl_q;
        evt_o.scl   = scl_c;
        evt_o.sda   = sda_c;
    end

endmodule

// File: rtl/wiper_slave_fsm.sv
module wiper_slave_fsm
    import wiper_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [2:0]        strap,
    output logic [BYTE_W-1:0] wiper0_o,
    output logic [BYTE_W-1:0] wiper1_o,
    output logic              sda_pull_o
);
    localparam int BIT_W = $clog2(BYTE_W);

    slv_state_e         state_q;
    rx_phase_e          phase_q;
    wr_mode_e           mode_q;
    logic               is_read_q;
    logic               ack_go_q;
    logic               rd_sel_q;
    logic [1:0]         data_idx_q;
    logic [BIT_W-1:0]   bit_q;
    logic [BYTE_W-1:0]  shift_q;
    logic [BYTE_W-1:0]  rx_byte;
    logic [BYTE_W-1:0]  tx_next;

    assign rx_byte = {shift_q[BYTE_W-2:0], evt.sda};
    assign tx_next = rd_sel_q ? wiper1_o : wiper0_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            phase_q    <= PH_CTRL;
            mode_q     <= WM_W0_ROLL;
            is_read_q  <= 1'b0;
            ack_go_q   <= 1'b0;
            rd_sel_q   <= 1'b0;
            data_idx_q <= '0;
            bit_q      <= '0;
            shift_q    <= '0;
            wiper0_o   <= '0;
            wiper1_o   <= '0;
            sda_pull_o <= 1'b0;
        end else if (evt.stop) begin
            state_q    <= ST_IDLE;
            sda_pull_o <= 1'b0;
        end else if (evt.start) begin
            state_q    <= ST_RX;
            phase_q    <= PH_CTRL;
            bit_q      <= '0;
            sda_pull_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RX: if (evt.rise) begin
                    shift_q <= rx_byte;
                    bit_q   <= bit_q + 1'b1;
                    if (bit_q == BIT_W'(BYTE_W - 1)) begin
                        state_q <= ST_ACK_WAIT;
                        unique case (phase_q)
                            PH_CTRL: begin
                                ack_go_q   <= ctrl_hit(rx_byte, DEV_CODE, strap);
                                is_read_q  <= rx_byte[0];
                                rd_sel_q   <= 1'b0;
                                data_idx_q <= '0;
                                phase_q    <= PH_CMD;
                            end
                            PH_CMD: begin
                                ack_go_q <= cmd_known(rx_byte);
                                mode_q   <= cmd_mode(rx_byte);
                                phase_q  <= PH_DATA;
                            end
                            default: begin
                                ack_go_q <= 1'b1;
                                if (data_idx_q != 2'd2)
                                    data_idx_q <= data_idx_q + 1'b1;
                                unique case (mode_q)
                                    WM_W0_ROLL: begin
                                        if (data_idx_q == 2'd0) wiper0_o <= rx_byte;
                                        if (data_idx_q == 2'd1) wiper1_o <= rx_byte;
                                    end
                                    WM_W1_ONLY: begin
                                        if (data_idx_q == 2'd0) wiper1_o <= rx_byte;
                                    end
                                    default: begin
                                        if (data_idx_q == 2'd0) begin
                                            wiper0_o <= rx_byte;
                                            wiper1_o <= rx_byte;
                                        end
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_ACK_WAIT: if (evt.fall) begin
                    if (ack_go_q) begin
                        sda_pull_o <= 1'b1;
                        state_q    <= ST_ACK;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_ACK: if (evt.fall) begin
                    bit_q <= '0;
                    if (is_read_q) begin
                        shift_q    <= tx_next;
                        sda_pull_o <= ~tx_next[BYTE_W-1];
                        state_q    <= ST_TX;
                    end else begin
                        sda_pull_o <= 1'b0;
                        state_q    <= ST_RX;
                    end
                end
                ST_TX: if (evt.fall) begin
                    if (bit_q == BIT_W'(BYTE_W - 1)) begin
                        sda_pull_o <= 1'b0;
                        state_q    <= ST_MACK;
                    end else begin
                        bit_q      <= bit_q + 1'b1;
                        shift_q    <= {shift_q[BYTE_W-2:0], 1'b0};
                        sda_pull_o <= ~shift_q[BYTE_W-2];
                    end
                end
                ST_MACK: begin
                    if (evt.rise) begin
                        if (evt.sda)
                            state_q <= ST_IDLE;
                        else
                            rd_sel_q <= ~rd_sel_q;
                    end else if (evt.fall) begin
                        bit_q      <= '0;
                        shift_q    <= tx_next;
                        sda_pull_o <= ~tx_next[BYTE_W-1];
                        state_q    <= ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1
    wiper_reset_chk: assert property (@(posedge clk)
        rst |=> (wiper0_o == '0) && (wiper1_o == '0) && !sda_pull_o);

    // R12
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !evt.scl);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !sda_pull_o);

    // R4
    wiper0_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper0_o) |-> $past(evt.rise));

    // R5
    wiper1_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper1_o) |-> $past(evt.rise));

    // R9
    nack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MACK && evt.rise && evt.sda && !evt.start && !evt.stop)
            |=> !sda_pull_o);

endmodule

// File: rtl/dual_wiper_i2c_ctrl.sv
module dual_wiper_i2c_ctrl
    import wiper_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_CYCLES = 12,
    parameter logic [3:0] DEV_CODE    = 4'b0101
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] addr_strap,
    output logic [7:0] wiper0,
    output logic [7:0] wiper1,
    output logic       sda_pull_low
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    bus_evt_t           evt;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_CYCLES (FILT_CYCLES)
        ) filt_i (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (raw_lines[g]),
            .clean_o (clean_lines[g])
        );
    end

    bus_event_detect evt_i (
        .clk   (clk),
        .rst   (rst),
        .scl_c (clean_lines[1]),
        .sda_c (clean_lines[0]),
        .evt_o (evt)
    );

    wiper_slave_fsm #(
        .DEV_CODE (DEV_CODE)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .strap      (addr_strap),
        .wiper0_o   (wiper0),
        .wiper1_o   (wiper1),
        .sda_pull_o (sda_pull_low)
    );

endmodule

// File: tb/dual_wiper_i2c_ctrl_tb.sv
`timescale 1ns/1ps
module dual_wiper_i2c_ctrl_tb_top;

    localparam int Q = 40;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] CW = 8'h5A;
    localparam logic [7:0] CR = 8'h5B;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] wiper0, wiper1;
    logic       sda_pull_low;
    logic       sda_bus;
    logic       pull_prev = 1'b0;
    int         checks = 0;
    int         errors = 0;
    int         r12_viol = 0;

    assign sda_bus = sda_m & ~sda_pull_low;

    always #2.5 clk = ~clk;

    dual_wiper_i2c_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl_m),
        .sda_in       (sda_bus),
        .addr_strap   (STRAP),
        .wiper0       (wiper0),
        .wiper1       (wiper1),
        .sda_pull_low (sda_pull_low)
    );

    // R12 monitor: a new pull-low must not start while the master holds SCL high
    always @(posedge clk) begin
        if (!rst && sda_pull_low && !pull_prev && scl_m) r12_viol++;
        pull_prev <= sda_pull_low;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quarter();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        sda_m = 1'b0; quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; quarter();
        scl_m = 1'b1; quarter();
        sda_m = 1'b1; quarter();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; quarter();
            scl_m = 1'b1; quarter(); quarter();
            scl_m = 1'b0; quarter();
        end
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        acked = (sda_bus == 1'b0);
        quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] v);
        sda_m = 1'b1;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            quarter();
            scl_m = 1'b1; quarter();
            v = {v[6:0], sda_bus};
            quarter();
            scl_m = 1'b0; quarter();
        end
        sda_m = ~master_ack; quarter();
        scl_m = 1'b1; quarter(); quarter();
        scl_m = 1'b0; quarter();
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 wiper0", wiper0, 8'h00);
        chk("R1 wiper1", wiper1, 8'h00);
        chk("R1 pull", {7'd0, sda_pull_low}, 8'h00);
    endtask

    task automatic t_write_roll();
        logic a;
        bus_start();
        send_byte(CW, a);    chk("R2 ctrl ack", {7'd0, a}, 8'h01);
        send_byte(8'hA9, a); chk("R4 cmd ack", {7'd0, a}, 8'h01);
        send_byte(8'h12, a);
        send_byte(8'h34, a);
        send_byte(8'h56, a); chk("R4 extra byte acked", {7'd0, a}, 8'h01);
        bus_stop();
        chk("R4 wiper0", wiper0, 8'h12);
        chk("R4 wiper1", wiper1, 8'h34);
    endtask

    task automatic t_write_w1();
        logic a;
        bus_start();
        send_byte(CW, a);
        send_byte(8'hAA, a); chk("R5 cmd ack", {7'd0, a}, 8'h01);
        send_byte(8'h77, a);
        bus_stop();
        chk("R5 wiper1", wiper1, 8'h77);
        chk("R5 wiper0 kept", wiper0, 8'h12);
    endtask

    task automatic t_write_both();
        logic a;
        bus_start();
        send_byte(CW, a);
        send_byte(8'hAF, a); chk("R6 cmd ack", {7'd0, a}, 8'h01);
        send_byte(8'hC3, a);
        send_byte(8'h99, a); chk("R6 extra byte acked", {7'd0, a}, 8'h01);
        bus_stop();
        chk("R6 wiper0", wiper0, 8'hC3);
        chk("R6 wiper1", wiper1, 8'hC3);
    endtask

    task automatic t_bad_ctrl();
        logic a;
        bus_start();
        send_byte(8'h56, a); chk("R3 wrong strap nack", {7'd0, a}, 8'h00);
        send_byte(8'hAF, a); chk("R3 ignored cmd", {7'd0, a}, 8'h00);
        send_byte(8'h01, a);
        bus_stop();
        bus_start();
        send_byte(8'h9A, a); chk("R3 wrong code nack", {7'd0, a}, 8'h00);
        bus_stop();
        chk("R3 wiper0 kept", wiper0, 8'hC3);
        chk("R3 wiper1 kept", wiper1, 8'hC3);
    endtask

    task automatic t_bad_cmd();
        logic a;
        bus_start();
        send_byte(CW, a);
        send_byte(8'h55, a); chk("R7 unknown cmd nack", {7'd0, a}, 8'h00);
        send_byte(8'h01, a); chk("R7 data ignored", {7'd0, a}, 8'h00);
        bus_stop();
        chk("R7 wiper0 kept", wiper0, 8'hC3);
        chk("R7 wiper1 kept", wiper1, 8'hC3);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(CW, a); send_byte(8'hA9, a);
        send_byte(8'h5E, a); send_byte(8'hA1, a);
        bus_stop();
        bus_start();
        send_byte(CR, a);     chk("R2 read ctrl ack", {7'd0, a}, 8'h01);
        recv_byte(1'b1, v);   chk("R8 first byte wiper0", v, 8'h5E);
        recv_byte(1'b1, v);   chk("R8 second byte wiper1", v, 8'hA1);
        recv_byte(1'b1, v);   chk("R8 wraps to wiper0", v, 8'h5E);
        recv_byte(1'b0, v);   chk("R8 fourth byte wiper1", v, 8'hA1);
        chk("R9 pull released", {7'd0, sda_pull_low}, 8'h00);
        chk("R9 bus high", {7'd0, sda_bus}, 8'h01);
        bus_stop();
    endtask

    task automatic t_rep_start();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(CW, a); send_byte(8'hA9, a); send_byte(8'h11, a);
        bus_start();
        send_byte(CR, a);   chk("R10 ctrl after repeated start", {7'd0, a}, 8'h01);
        recv_byte(1'b0, v); chk("R10 read after repeated start", v, 8'h11);
        bus_stop();
    endtask

    task automatic t_glitch();
        logic a;
        bus_start();
        send_byte(CW, a); send_byte(8'hAA, a);
        scl_m = 1'b1;
        repeat (5) @(negedge clk);
        scl_m = 1'b0;
        quarter();
        send_byte(8'h3C, a); chk("R11 ack after glitch", {7'd0, a}, 8'h01);
        bus_stop();
        chk("R11 wiper1 after glitch", wiper1, 8'h3C);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_roll();
        t_write_w1();
        t_write_both();
        t_bad_ctrl();
        t_bad_cmd();
        t_read();
        t_rep_start();
        t_glitch();
        chk("R12 pull edges during SCL high", r12_viol[7:0], 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule